// File: doc/BRIEF.md
# Event Counter Pair with Pin and Interrupt Response

This block counts activity on pre-selected event lines, one line per counter, and reacts to that activity on two kinds of output. Every counter owns a response control byte. The byte picks how the counter follows its event: stopped, counting every high cycle, counting rising edges, or a trigger mode that starts on the first rising edge and then runs every cycle. The same byte picks whether the counter's active-low monitor pin pulses on an event or on a counter wrap. It also picks whether the counter raises the shared active-low interrupt request on an event or on a wrap.

Software reaches the counters, the control bytes and a status word through a plain single-cycle register port, with a combinational read. When a counter raises an interrupt, the status word keeps a flag for that counter. The interrupt output stays low while any flag is set, and software clears a flag by writing a one to its bit. The defaults are two counters of 32 bits. A new control byte takes effect from the clock edge after the one that writes it.

Top module: `pmu_top`

## Requirements
- R1: After reset, all counters, control bytes and status flags read 0, irq_n is 1, every mon_n bit is 1 and every mon_oe bit is 0. The address is {region[1:0], index}: region 0 is a counter, region 1 is a control byte and region 2 is the status word. A counter reads back the value written to it. A control byte stores wdata[7:0] and reads back zero-extended.
- R2: When count mode (control bits 3:2) is 0, the counter holds its value whatever the event does.
- R3: When count mode is 1, the counter increments by one on every clock edge at which its event is high.
- R4: When count mode is 2, the counter increments once per rising edge of its event. A rising edge means the event is high now and was low at the previous edge; the remembered copy of the event resets low.
- R5: When count mode is 3, the counter does not move until the first rising edge of its event. It increments at that edge and at every edge after it, whatever the event level.
- R6: When pin mode (control bits 5:4) is 2, mon_oe for that counter is 1. The counter's mon_n is 0 for exactly the one cycle that follows each clock edge where a rising edge of its event is seen.
- R7: An increment from all ones wraps the counter to 0, and that edge is an overflow.
- R8: When pin mode is 3, mon_oe is 1 and mon_n is 0 for the one cycle that follows an overflow edge.
- R9: When interrupt mode (control bits 7:6) is 2, a rising edge of the event sets the counter's status flag (bit index = counter index). When interrupt mode is 3, an overflow sets the flag. irq_n is 0 while any flag is set.
- R10: Writing the status word clears exactly the flags whose wdata bit is 1. Other flags stay set.
- R11: Pin mode 0 or 1 drives mon_oe to 0 and mon_n to 1. Interrupt mode 0 or 1 never sets a flag.
- R12: Writing a counter's control byte or the counter itself returns trigger mode to waiting for a new first rising edge. A write to a counter takes priority over an increment at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt | input | NUM_CTR | Pre-selected event line, one per counter |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address {region, index} |
| wdata | input | CNT_W | Register write data |
| rdata | output | CNT_W | Combinational register read data |
| mon_n | output | NUM_CTR | Active-low monitor pulse, one per counter |
| mon_oe | output | NUM_CTR | Output enable for each monitor pin |
| irq_n | output | 1 | Shared active-low interrupt request |

## Verification
Most faults in the hidden state appear at the ports within a cycle or two. A remembered event copy that is stuck or missing shows up as extra counts while the event is held high, and as a monitor pulse lasting more than one cycle. A trigger state that fails to arm shows as a counter frozen after a rising edge. A trigger state that fails to clear shows as counts in idle cycles after a control rewrite. A status flag that sets or clears wrongly holds irq_n at the wrong level on the cycle right after the event or the status write. A wrap that goes wrong shows as a count or a missing pin pulse on the edge after all ones.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  typedef enum logic [1:0] {
    CM_STOP  = 2'd0,
    CM_LEVEL = 2'd1,
    CM_EDGE  = 2'd2,
    CM_TRIG  = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    RSP_OFF   = 2'd0,
    RSP_RSVD  = 2'd1,
    RSP_EVENT = 2'd2,
    RSP_OVF   = 2'd3
  } rsp_sel_e;

  typedef struct packed {
    rsp_sel_e  irq_sel;
    rsp_sel_e  pin_sel;
    cnt_mode_e cmode;
    logic [1:0] spare;
  } ctl_byte_t;

  localparam logic [1:0] RGN_CNT = 2'd0;
  localparam logic [1:0] RGN_CTL = 2'd1;
  localparam logic [1:0] RGN_STS = 2'd2;

endpackage

// File: rtl/pmu_qualifier.sv
module pmu_qualifier
  import pmu_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      evt,
  input  cnt_mode_e cmode,
  input  logic      restart,
  output logic      rise,
  output logic      inc
);

  logic evt_q;
  logic run_q;
  logic run_d;

  assign rise = evt & ~evt_q;

  always_comb begin
    case (cmode)
      CM_LEVEL: inc = evt;
      CM_EDGE:  inc = rise;
      CM_TRIG:  inc = run_q | rise;
      default:  inc = 1'b0;
    endcase
  end

  always_comb begin
    run_d = run_q;
    if (restart) begin
      run_d = 1'b0;
    end else if ((cmode == CM_TRIG) && rise) begin
      run_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      evt_q <= evt;
      run_q <= run_d;
    end
  end

endmodule

// File: rtl/pmu_slice.sv
module pmu_slice
  import pmu_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             cnt_we,
  input  logic             ctl_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [7:0]       ctl,
  output logic             irq_src,
  output logic             mon_n,
  output logic             mon_oe
);

  ctl_byte_t        ctl_q;
  ctl_byte_t        ctl_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             mon_n_q;
  logic             rise;
  logic             inc;
  logic             ovf;
  logic             pin_fire;

  pmu_qualifier u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt),
    .cmode   (ctl_q.cmode),
    .restart (cnt_we | ctl_we),
    .rise    (rise),
    .inc     (inc)
  );

  // wrap edge: increment from all ones, not overridden by software
  assign ovf = inc & (&cnt_q) & ~cnt_we;

  always_comb begin
    cnt_en = cnt_we | inc;
    if (cnt_we) begin
      cnt_d = wdata;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  assign ctl_d = ctl_we ? ctl_byte_t'(wdata[7:0]) : ctl_q;

  always_comb begin
    case (ctl_q.pin_sel)
      RSP_EVENT: pin_fire = rise;
      RSP_OVF:   pin_fire = ovf;
      default:   pin_fire = 1'b0;
    endcase
  end

  always_comb begin
    case (ctl_q.irq_sel)
      RSP_EVENT: irq_src = rise;
      RSP_OVF:   irq_src = ovf;
      default:   irq_src = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= ctl_byte_t'(8'h00);
      mon_n_q <= 1'b1;
    end else begin
      ctl_q   <= ctl_d;
      mon_n_q <= ~pin_fire;
    end
  end

  assign cnt    = cnt_q;
  assign ctl    = ctl_q;
  assign mon_n  = mon_n_q;
  assign mon_oe = (ctl_q.pin_sel == RSP_EVENT) || (ctl_q.pin_sel == RSP_OVF);

endmodule

// File: rtl/pmu_status.sv
module pmu_status #(
  parameter int NUM_CTR = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTR-1:0] set_vec,
  input  logic               clr_we,
  input  logic [NUM_CTR-1:0] clr_mask,
  output logic [NUM_CTR-1:0] flags,
  output logic               irq_n
);

  logic [NUM_CTR-1:0] flags_q;
  logic [NUM_CTR-1:0] flags_d;
  logic [NUM_CTR-1:0] keep;

  always_comb begin
    keep    = clr_we ? ~clr_mask : '1;
    flags_d = set_vec | (flags_q & keep);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_d;
    end
  end

  assign flags = flags_q;
  assign irq_n = ~(|flags_q);

endmodule

// File: rtl/pmu_top.sv
module pmu_top
  import pmu_pkg::*;
#(
  parameter  int NUM_CTR = 2,
  parameter  int CNT_W   = 32,
  localparam int IDX_W   = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1,
  localparam int ADDR_W  = IDX_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTR-1:0] evt,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [CNT_W-1:0]   wdata,
  output logic [CNT_W-1:0]   rdata,
  output logic [NUM_CTR-1:0] mon_n,
  output logic [NUM_CTR-1:0] mon_oe,
  output logic               irq_n
);

  logic [1:0]                    rgn;
  logic [IDX_W-1:0]              idx;
  logic [NUM_CTR-1:0]            cnt_we;
  logic [NUM_CTR-1:0]            ctl_we;
  logic                          sts_we;
  logic [NUM_CTR-1:0][CNT_W-1:0] cnt_arr;
  logic [NUM_CTR-1:0][7:0]       ctl_arr;
  logic [NUM_CTR-1:0]            irq_src;
  logic [NUM_CTR-1:0]            flags;

  assign rgn    = addr[ADDR_W-1 -: 2];
  assign idx    = addr[IDX_W-1:0];
  assign sts_we = wr_en && (rgn == RGN_STS);

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    assign cnt_we[g] = wr_en && (rgn == RGN_CNT) && (idx == IDX_W'(g));
    assign ctl_we[g] = wr_en && (rgn == RGN_CTL) && (idx == IDX_W'(g));

    pmu_slice #(
      .CNT_W (CNT_W)
    ) u_slice (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt[g]),
      .cnt_we  (cnt_we[g]),
      .ctl_we  (ctl_we[g]),
      .wdata   (wdata),
      .cnt     (cnt_arr[g]),
      .ctl     (ctl_arr[g]),
      .irq_src (irq_src[g]),
      .mon_n   (mon_n[g]),
      .mon_oe  (mon_oe[g])
    );
  end

  pmu_status #(
    .NUM_CTR (NUM_CTR)
  ) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (irq_src),
    .clr_we   (sts_we),
    .clr_mask (wdata[NUM_CTR-1:0]),
    .flags    (flags),
    .irq_n    (irq_n)
  );

  always_comb begin
    rdata = '0;
    case (rgn)
      RGN_CNT: begin
        for (int k = 0; k < NUM_CTR; k++) begin
          if (idx == IDX_W'(k)) rdata = cnt_arr[k];
        end
      end
      RGN_CTL: begin
        for (int k = 0; k < NUM_CTR; k++) begin
          if (idx == IDX_W'(k)) rdata = CNT_W'(ctl_arr[k]);
        end
      end
      RGN_STS: rdata = CNT_W'(flags);
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/pmu_chk.sv
module pmu_chk #(
  parameter int NUM_CTR = 2,
  parameter int CNT_W   = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_CTR-1:0]            evt,
  input logic [NUM_CTR-1:0]            cnt_we,
  input logic                          sts_we,
  input logic [CNT_W-1:0]              wdata,
  input logic [NUM_CTR-1:0][CNT_W-1:0] cnt_arr,
  input logic [NUM_CTR-1:0][7:0]       ctl_arr,
  input logic [NUM_CTR-1:0]            irq_src,
  input logic [NUM_CTR-1:0]            mon_n,
  input logic                          irq_n
);

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_chk
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_arr[g][3:2] == 2'd0 && !cnt_we[g]) |=> (cnt_arr[g] == $past(cnt_arr[g])))
      else $error("stopped counter moved"); // R2

    AST_LEVEL_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_arr[g][3:2] == 2'd1 && evt[g] && !cnt_we[g]) |=> (cnt_arr[g] == $past(cnt_arr[g]) + CNT_W'(1)))
      else $error("level count missed"); // R3

    AST_OVF_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_arr[g][5:4] == 2'd3 && ctl_arr[g][3:2] == 2'd1 && evt[g] && (&cnt_arr[g]) && !cnt_we[g]) |=> !mon_n[g])
      else $error("overflow pin pulse missing"); // R8
  end

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_we && (&wdata[NUM_CTR-1:0]) && (irq_src == '0)) |=> irq_n)
    else $error("interrupt stayed low after full clear"); // R10

endmodule

bind pmu_top pmu_chk #(
  .NUM_CTR (NUM_CTR),
  .CNT_W   (CNT_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .evt     (evt),
  .cnt_we  (cnt_we),
  .sts_we  (sts_we),
  .wdata   (wdata),
  .cnt_arr (cnt_arr),
  .ctl_arr (ctl_arr),
  .irq_src (irq_src),
  .mon_n   (mon_n),
  .irq_n   (irq_n)
);

// File: tb/pmu_top_test.sv
module pmu_top_test;

  logic        clk;
  logic        rst_n;
  logic [1:0]  evt;
  logic        wr_en;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [1:0]  mon_n;
  logic [1:0]  mon_oe;
  logic        irq_n;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    bit          is_pin;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];

  pmu_top uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .mon_n  (mon_n),
    .mon_oe (mon_oe),
    .irq_n  (irq_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // monitor: pops one expected item per cycle, away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb.pop_front();
      act = it.is_pin ? {27'd0, irq_n, mon_n, mon_oe} : rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr  = a;
    wdata = d;
    wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    addr      = a;
    it.is_pin = 1'b0;
    it.exp    = e;
    it.tag    = tag;
    sb.push_back(it);
    tick();
  endtask

  // expected {irq_n, mon_n[1:0], mon_oe[1:0]}
  task automatic pin(input logic [4:0] e, input string tag);
    item_t it;
    it.is_pin = 1'b1;
    it.exp    = {27'd0, e};
    it.tag    = tag;
    sb.push_back(it);
    tick();
  endtask

  task automatic idle(input int n);
    repeat (n) tick();
  endtask

  task automatic hold_evt(input int i, input int n);
    evt[i] = 1'b1;
    repeat (n) tick();
    evt[i] = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // address map: 0/1 counters, 2/3 control bytes, 4 status
  initial begin
    rst_n = 1'b0;
    evt   = '0;
    wr_en = 1'b0;
    addr  = '0;
    wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R1 reset state and register access
    rd(3'd0, 32'h0, "R1 cnt0 reset");
    rd(3'd1, 32'h0, "R1 cnt1 reset");
    rd(3'd2, 32'h0, "R1 ctl0 reset");
    rd(3'd4, 32'h0, "R1 status reset");
    pin(5'b1_11_00, "R1 pins reset");
    wr(3'd0, 32'hA5A5_0001);
    rd(3'd0, 32'hA5A5_0001, "R1 cnt0 readback");
    wr(3'd2, 32'h0000_01F3);
    rd(3'd2, 32'h0000_00F3, "R1 ctl0 readback");
    wr(3'd2, 32'h0);

    // R3 level count
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h04);
    hold_evt(0, 5);
    rd(3'd0, 32'd5, "R3 level count");

    // R4 edge count
    wr(3'd3, 32'h08);
    hold_evt(1, 3);
    idle(2);
    hold_evt(1, 1);
    idle(1);
    rd(3'd1, 32'd2, "R4 edge count");

    // R2 stop
    wr(3'd2, 32'h00);
    hold_evt(0, 3);
    rd(3'd0, 32'd5, "R2 stopped");

    // R5 trigger
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h0C);
    idle(3);
    rd(3'd0, 32'd0, "R5 trigger waits");
    hold_evt(0, 1);
    idle(4);
    wr(3'd2, 32'h00);
    rd(3'd0, 32'd6, "R5 trigger runs");

    // R12 trigger restart
    wr(3'd2, 32'h0C);
    idle(3);
    rd(3'd0, 32'd6, "R12 rewrite disarms");
    hold_evt(0, 1);
    idle(1);
    wr(3'd0, 32'd100);
    idle(2);
    rd(3'd0, 32'd100, "R12 counter write disarms");
    wr(3'd2, 32'h00);

    // R6 pin on event
    wr(3'd2, 32'h20);
    pin(5'b1_11_01, "R6 pin idle");
    evt[0] = 1'b1;
    tick();
    pin(5'b1_10_01, "R6 pin pulse");
    pin(5'b1_11_01, "R6 pin one cycle");
    evt[0] = 1'b0;
    tick();
    rd(3'd0, 32'd100, "R2 stopped with pin mode");

    // R11 reserved encodings
    wr(3'd2, 32'h50);
    pin(5'b1_11_00, "R11 pin off");
    hold_evt(0, 1);
    pin(5'b1_11_00, "R11 no pulse");
    rd(3'd4, 32'h0, "R11 no flag");

    // R7 / R8 wrap with pin on overflow
    wr(3'd1, 32'hFFFF_FFFE);
    wr(3'd3, 32'h34);
    evt[1] = 1'b1;
    tick();
    tick();
    evt[1] = 1'b0;
    pin(5'b1_01_10, "R8 overflow pulse");
    pin(5'b1_11_10, "R8 pulse one cycle");
    rd(3'd1, 32'h0, "R7 wrap to zero");

    // R9 interrupt on event, R10 clear
    wr(3'd2, 32'h80);
    evt[0] = 1'b1;
    tick();
    evt[0] = 1'b0;
    pin(5'b0_11_10, "R9 irq low on event");
    rd(3'd4, 32'h1, "R9 flag0 set");
    wr(3'd4, 32'h2);
    rd(3'd4, 32'h1, "R10 other bit kept");
    wr(3'd4, 32'h1);
    rd(3'd4, 32'h0, "R10 flag cleared");
    pin(5'b1_11_10, "R10 irq released");

    // R9 interrupt on overflow
    wr(3'd3, 32'hC4);
    wr(3'd1, 32'hFFFF_FFFF);
    hold_evt(1, 1);
    rd(3'd4, 32'h2, "R9 flag1 on overflow");
    pin(5'b0_11_00, "R9 irq low on overflow");
    rd(3'd1, 32'h0, "R7 wrap again");

    idle(2);
    if (sb.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
    end
    finish_run();
  end

endmodule